// File: doc/BRIEF.md
# Word-to-Byte Bus Access Sequencer

This block sits between a 16-bit internal data path and an 8-bit external memory bus addressed by 20-bit byte addresses (1M byte locations). An internal client presents a request carrying a byte address, a direction flag, a size flag (one byte or one 16-bit word) and 16 bits of write data. A word request becomes two external byte cycles back to back, and a byte request becomes one. Words are stored little-endian: the low byte lives at the request address and the high byte at the next address. For example, writing word 5A2F at 18000 puts 2F at 18000 and 5A at 18001.

Each external cycle drives the address, raises exactly one of the read or write strobes, and holds everything steady until the memory side signals ready. Read bytes are assembled into a 16-bit result, and a one-cycle done pulse marks the end of the request. A busy output covers the whole request, and requests that arrive while busy are dropped.

The controller has four states. IDLE waits for a request; a request seen at a clock edge in IDLE is accepted (IDLE to LO_CYC). LO_CYC runs the low-byte cycle at the request address and stays there while ready is low. When ready is high it moves to HI_CYC for a word, or to FINISH for a byte. HI_CYC runs the high-byte cycle at address+1 and stays there while ready is low; when ready is high it moves to FINISH. FINISH raises done for one cycle and always returns to IDLE.

Top module: `bytebus_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, done, bus_rd and bus_wr are low and rdata is 0000.
- R2: A request with req_valid high at a clock edge in IDLE is accepted. From the next cycle busy is high and the first byte cycle's strobe and address are driven.
- R3: A request presented while busy is high has no effect: no extra bus cycle follows and no memory location is touched.
- R4: A word access runs the low-byte cycle at req_addr first, then the high-byte cycle at req_addr+1.
- R5: The high-byte address wraps modulo 2^20, so a word at FFFFF uses FFFFF and then 00000.
- R6: A byte access performs exactly one external cycle at req_addr.
- R7: During a byte cycle exactly one strobe is high: bus_rd for reads (req_write=0) and bus_wr for writes (req_write=1). Address, strobe and write data stay unchanged until an edge with bus_ready high ends the cycle.
- R8: A write drives req_wdata[7:0] on bus_dout in the low-byte cycle and req_wdata[15:8] in the high-byte cycle.
- R9: A read places the low-byte cycle's data in rdata[7:0] and the high-byte cycle's data in rdata[15:8]. A byte read (req_word=0) sets rdata[15:8] to zero.
- R10: done is a single-cycle pulse in the cycle after the edge that ends the last byte cycle. busy stays high from the cycle after acceptance through the done cycle, and the block is back in IDLE in the next cycle.
- R11: Write requests leave rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | 20 | Byte address of the access (low byte for words) |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read result |
| bus_addr | output | 20 | External byte address |
| bus_rd | output | 1 | External read strobe |
| bus_wr | output | 1 | External write strobe |
| bus_dout | output | 8 | External write data |
| bus_din | input | 8 | External read data |
| bus_ready | input | 1 | Memory side ends the current byte cycle at this edge |

## Verification
After the accepting edge, busy, the strobe and the low-byte address appear one cycle later. Each byte cycle ends at the first edge where ready is high, and the next cycle (high byte or FINISH) is visible right after that edge. done, and the fully assembled rdata, show up one edge after the final ready. The bench drives inputs and the ready and data of its memory model on falling edges. A behavioural model advances on each rising edge, and every output is compared against it at the following falling edge, so each result is checked in exactly the cycle it falls due. Memory contents and returned words are also checked directly against the little-endian layout after each request.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LO_CYC = 2'd1,
        ST_HI_CYC = 2'd2,
        ST_FINISH = 2'd3
    } bbs_state_t;

endpackage

// File: rtl/bbs_fsm.sv
module bbs_fsm
    import bbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ready,
    input  logic       word_q,
    output bbs_state_t state,
    output logic       accept,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       strobe_en,
    output logic       sel_hi,
    output logic       busy,
    output logic       done
);

    bbs_state_t state_q;
    bbs_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LO_CYC;
            end
            ST_LO_CYC: begin
                if (bus_ready) state_d = word_q ? ST_HI_CYC : ST_FINISH;
            end
            ST_HI_CYC: begin
                if (bus_ready) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        strobe_en = 1'b0;
        sel_hi    = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = req_valid;
            end
            ST_LO_CYC: begin
                busy      = 1'b1;
                strobe_en = 1'b1;
                cap_lo    = bus_ready;
            end
            ST_HI_CYC: begin
                busy      = 1'b1;
                strobe_en = 1'b1;
                sel_hi    = 1'b1;
                cap_hi    = bus_ready;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R10: FINISH lasts exactly one cycle and leads back to IDLE
    assert_finish_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));

    // R3: once past the low cycle, no new low cycle can start without IDLE
    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_CYC || state_q == ST_FINISH) |=> (state_q != ST_LO_CYC));

    // R6: a byte request never enters the high-byte cycle
    assert_byte_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO_CYC && bus_ready && !word_q) |=> (state_q == ST_FINISH));

endmodule

// File: rtl/bbs_req_hold.sv
module bbs_req_hold #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              sel_hi,
    output logic              write_q,
    output logic              word_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_dout
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] addr_lo_q;
    logic [ADDR_W-1:0] addr_hi_q;
    logic [WORD_W-1:0] wdata_q;

    // capture the request; the high-byte address is formed once here,
    // wrapping naturally at the top of the address space
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q   <= 1'b0;
            word_q    <= 1'b0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            wdata_q   <= '0;
        end else if (accept) begin
            write_q   <= req_write;
            word_q    <= req_word;
            addr_lo_q <= req_addr;
            addr_hi_q <= req_addr + ADDR_ONE;
            wdata_q   <= req_wdata;
        end
    end

    always_comb begin
        bus_addr = sel_hi ? addr_hi_q : addr_lo_q;
        bus_dout = sel_hi ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
    end

endmodule

// File: rtl/bbs_rd_asm.sv
module bbs_rd_asm #(
    parameter int BYTE_W = 8,
    localparam int LANES  = 2,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              write_q,
    input  logic              word_q,
    input  logic [BYTE_W-1:0] bus_din,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] rdata_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic load;
        logic clear;
        if (g == 0) begin : g_low
            assign load  = cap_lo && !write_q;
            assign clear = 1'b0;
        end else begin : g_high
            assign load  = cap_hi && !write_q;
            // a byte read zero-fills the upper half
            assign clear = cap_lo && !write_q && !word_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (load) begin
                rdata_q[g*BYTE_W +: BYTE_W] <= bus_din;
            end else if (clear) begin
                rdata_q[g*BYTE_W +: BYTE_W] <= '0;
            end
        end
    end

    assign rdata = rdata_q;

    // R11: completing a write byte cycle leaves the result untouched
    assert_write_keeps_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_lo || cap_hi) && write_q) |=> $stable(rdata_q));

    // R9: the low lane takes the bus byte on a read low cycle
    assert_low_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lo && !write_q) |=> (rdata_q[BYTE_W-1:0] == $past(bus_din)));

endmodule

// File: rtl/bytebus_seq.sv
module bytebus_seq
    import bbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [BYTE_W-1:0] bus_dout,
    input  logic [BYTE_W-1:0] bus_din,
    input  logic              bus_ready
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    bbs_state_t state;
    logic       accept;
    logic       cap_lo;
    logic       cap_hi;
    logic       strobe_en;
    logic       sel_hi;
    logic       write_q;
    logic       word_q;

    bbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .word_q    (word_q),
        .state     (state),
        .accept    (accept),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .strobe_en (strobe_en),
        .sel_hi    (sel_hi),
        .busy      (busy),
        .done      (done)
    );

    bbs_req_hold #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_hi    (sel_hi),
        .write_q   (write_q),
        .word_q    (word_q),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout)
    );

    bbs_rd_asm #(
        .BYTE_W (BYTE_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .write_q (write_q),
        .word_q  (word_q),
        .bus_din (bus_din),
        .rdata   (rdata)
    );

    assign bus_rd = strobe_en && !write_q;
    assign bus_wr = strobe_en &&  write_q;

    // R7: never both strobes
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R7: a cycle without ready keeps address, strobe and data steady
    assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_ready) |=>
            ((bus_rd || bus_wr) && $stable(bus_addr) && $stable(bus_rd)
             && $stable(bus_wr) && $stable(bus_dout)));

    // R4 / R5: the high-byte cycle follows at address+1, modulo 2^ADDR_W
    assert_hi_addr_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO_CYC && bus_ready && word_q) |=>
            (bus_addr == $past(bus_addr) + ADDR_ONE));

    // R10: done only inside busy, and only for one cycle
    assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an accepted request starts a strobed cycle next
    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && (bus_rd || bus_wr)));

    // R9: a finished byte read has a zero upper half
    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !write_q && !word_q) |-> (rdata[WORD_W-1:BYTE_W] == '0));

endmodule

// File: tb/bytebus_seq_test.sv
`timescale 1ns/1ps
module bytebus_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic        req_word;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic        busy;
    logic        done;
    logic [15:0] rdata;
    logic [19:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din;
    logic        bus_ready;

    always #2.5 clk = ~clk;

    bytebus_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_dout  (bus_dout),
        .bus_din   (bus_din),
        .bus_ready (bus_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int waits = 0;
    int age   = 0;
    int nbus  = 0;
    logic [7:0] mem [int];

    // behavioural reference: 0 idle, 1 low byte, 2 high byte, 3 finish
    int          m_state;
    logic [19:0] m_addr;
    logic        m_write;
    logic        m_word;
    logic [15:0] m_wdata;
    logic [15:0] m_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_mem(input logic [19:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_state = 0;
            m_rdata = 16'h0000;
        end else begin
            case (m_state)
                0: if (req_valid) begin
                       m_addr  = req_addr;
                       m_write = req_write;
                       m_word  = req_word;
                       m_wdata = req_wdata;
                       m_state = 1;
                   end
                1: if (bus_ready) begin
                       if (!m_write) begin
                           m_rdata[7:0] = bus_din;
                           if (!m_word) m_rdata[15:8] = 8'h00;
                       end
                       m_state = m_word ? 2 : 3;
                   end
                2: if (bus_ready) begin
                       if (!m_write) m_rdata[15:8] = bus_din;
                       m_state = 3;
                   end
                default: m_state = 0;
            endcase
        end
    endtask

    task automatic compare();
        logic strobe;
        logic [19:0] e_addr;
        strobe = (m_state == 1 || m_state == 2);
        e_addr = (m_state == 2) ? m_addr + 20'd1 : m_addr;
        chk("R10 busy", 32'(busy), 32'(m_state != 0));
        chk("R10 done", 32'(done), 32'(m_state == 3));
        chk("R7 bus_rd", 32'(bus_rd), 32'(strobe && !m_write));
        chk("R7 bus_wr", 32'(bus_wr), 32'(strobe && m_write));
        if (strobe) chk("R4 bus_addr", 32'(bus_addr), 32'(e_addr));
        if (strobe && m_write)
            chk("R8 bus_dout", 32'(bus_dout), 32'((m_state == 2) ? m_wdata[15:8] : m_wdata[7:0]));
        chk("R9 rdata", 32'(rdata), 32'(m_rdata));
    endtask

    task automatic slave();
        if (bus_rd || bus_wr) begin
            bus_din = rd_mem(bus_addr);
            if (age >= waits) begin
                bus_ready = 1'b1;
                age = 0;
                nbus++;
                if (bus_wr) mem[int'(bus_addr)] = bus_dout;
            end else begin
                bus_ready = 1'b0;
                age++;
            end
        end else begin
            bus_ready = 1'b0;
            age = 0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        slave();
    endtask

    // noisy=1 presents foreign write requests while busy (R3)
    task automatic run_req(input logic w, input logic wd, input logic [19:0] a,
                           input logic [15:0] d, input bit noisy);
        bit seen;
        seen = 0;
        req_valid = 1'b1;
        req_write = w;
        req_word  = wd;
        req_addr  = a;
        req_wdata = d;
        tick();
        req_valid = 1'b0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (done) begin
                seen = 1;
                break;
            end
            if (noisy && busy) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_word  = 1'b1;
                req_addr  = 20'h0ABCD;
                req_wdata = 16'hDEAD;
            end
        end
        req_valid = 1'b0;
        if (!seen) chk("R10 done timeout", 32'd0, 32'd1);
        tick();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int nb;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_word  = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        bus_din   = '0;
        bus_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1 reset busy", 32'(busy), 32'd0);
            chk("R1 reset strobes", 32'({bus_rd, bus_wr, done}), 32'd0);
            chk("R1 reset rdata", 32'(rdata), 32'h0000);
        end
        rst_n = 1'b1;
        tick();
        chk("R1 after reset idle", 32'({busy, bus_rd, bus_wr}), 32'd0);

        // R2: acceptance is visible one cycle later
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
        req_addr = 20'h18000; req_wdata = 16'h5A2F;
        nb = nbus;
        tick();
        req_valid = 1'b0;
        chk("R2 busy after accept", 32'(busy), 32'd1);
        chk("R2 write strobe", 32'(bus_wr), 32'd1);
        chk("R2 low address", 32'(bus_addr), 32'h18000);
        while (!done) tick();
        tick();
        chk("R4 low byte at addr", 32'(rd_mem(20'h18000)), 32'h2F);
        chk("R4 high byte at addr+1", 32'(rd_mem(20'h18001)), 32'h5A);
        chk("R4 two bus cycles", 32'(nbus - nb), 32'd2);

        // R9: word read with wait states
        waits = 2;
        run_req(1'b0, 1'b1, 20'h18000, 16'h0000, 0);
        chk("R9 word read", 32'(rdata), 32'h5A2F);

        // R6: byte write then byte read, one cycle each
        waits = 1;
        nb = nbus;
        run_req(1'b1, 1'b0, 20'h00123, 16'hCC77, 0);
        chk("R6 byte write single cycle", 32'(nbus - nb), 32'd1);
        chk("R6 byte written", 32'(rd_mem(20'h00123)), 32'h77);
        chk("R6 neighbour untouched", 32'(rd_mem(20'h00124)), 32'h00);
        chk("R11 write keeps rdata", 32'(rdata), 32'h5A2F);
        nb = nbus;
        run_req(1'b0, 1'b0, 20'h00123, 16'h0000, 0);
        chk("R6 byte read single cycle", 32'(nbus - nb), 32'd1);
        chk("R9 byte read zero fill", 32'(rdata), 32'h0077);

        // R5: wrap at the top of the address space
        waits = 0;
        run_req(1'b1, 1'b1, 20'hFFFFF, 16'hBEEF, 0);
        chk("R5 low byte at FFFFF", 32'(rd_mem(20'hFFFFF)), 32'hEF);
        chk("R5 high byte wraps to 00000", 32'(rd_mem(20'h00000)), 32'hBE);
        chk("R11 rdata after word write", 32'(rdata), 32'h0077);
        waits = 3;
        run_req(1'b0, 1'b1, 20'hFFFFF, 16'h0000, 0);
        chk("R5 wrapped read", 32'(rdata), 32'hBEEF);

        // R3: requests while busy are dropped
        waits = 2;
        nb = nbus;
        run_req(1'b0, 1'b1, 20'h18000, 16'h0000, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 idle after noisy request", 32'({busy, bus_rd, bus_wr}), 32'd0);
        end
        chk("R3 only two bus cycles", 32'(nbus - nb), 32'd2);
        chk("R3 foreign address untouched", 32'(mem.exists(32'h0ABCD)), 32'd0);
        chk("R9 read during noise", 32'(rdata), 32'h5A2F);

        // back-to-back requests with ready always on
        waits = 0;
        run_req(1'b1, 1'b1, 20'h40000, 16'h1234, 0);
        run_req(1'b0, 1'b0, 20'h40001, 16'h0000, 0);
        chk("R9 high byte read alone", 32'(rdata), 32'h0012);
        run_req(1'b0, 1'b1, 20'h40000, 16'h0000, 0);
        chk("R9 word read back", 32'(rdata), 32'h1234);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule